// File: doc/BRIEF.md
# Keyed Flow Classification Hash Engine

This block turns a flow tuple into the 32-bit word that a hash-bucketed packet filter table uses to place or find an entry. The tuple arrives as fourteen 32-bit words: word 0 holds the flow type, pool and VLAN information, and words 1 to 13 hold the addresses, ports and flexible bytes. Two 32-bit keys drive a shifted-XOR fold over that tuple. The bucket key produces the bucket index. The signature key produces a 16-bit signature.

The bucket index is cut to a width that depends on the match mode and on the table-size code. In perfect-match mode the caller's software index fills the upper half of the result. In signature mode the signature fills the upper half. A one-cycle `start` pulse captures all inputs. One clock later `done` pulses and the result appears. The result stays unchanged until the next `start`.

Top module: `flow_hash_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done` and `hash_word` are 0 after that edge.
- R2: A `start` sampled high at a clock edge makes `done` high after that same edge. `done` is low after every edge at which `start` was low, so each start gives exactly one done cycle.
- R3: `hash_word` does not change at any edge where `start` is low, whatever the other inputs do.
- R4: Word k of the tuple is `flow_words[32k+31:32k]`. The common word is the XOR of words 1 to 13. Word 0 is the flow word. Only the XOR of words 1 to 13 affects the result, not how the bits are split among those words.
- R5: The fold works as follows.
  - Start with `lo` = the common word with its 16-bit halves swapped, and `hi` = common ^ flow ^ (flow >> 16).
  - Then XOR `lo` into the result if key bit 0 is set, and XOR `hi` into the result if key bit 16 is set.
  - Only after that, update `lo` ^= flow ^ (flow << 16).
  - Then, for i from 1 to 15, XOR (`lo` >> i) into the result if key bit i is set, and XOR (`hi` >> i) into the result if key bit 16+i is set.
  - The fold value is bits 15:0 of the result.
- R6: When `sig_mode`=0 (perfect match), the bucket index is the bucket-key fold masked to 11, 12 or 13 bits for size codes 1, 2 and 3. Size code 0 uses the 11-bit mask.
- R7: When `sig_mode`=1, the bucket index is masked to 13, 14 or 15 bits for size codes 1, 2 and 3. Size code 0 uses the 13-bit mask.
- R8: When `sig_mode`=1, `hash_word` = {signature-key fold, bucket index in bits 15:0}.
- R9: When `sig_mode`=0, `hash_word` = {`sw_index`, bucket index in bits 15:0}. The signature key has no effect in this mode.
- R10: A `start` held high on consecutive edges is accepted at each edge. The results come out on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture inputs and compute at this edge |
| flow_words | input | 448 | Flow tuple, word k at bits 32k+31:32k |
| bucket_key | input | 32 | Key for the bucket fold |
| sig_key | input | 32 | Key for the signature fold |
| size_code | input | 2 | Table-size code, 0..3 |
| sig_mode | input | 1 | 1 = signature mode, 0 = perfect mode |
| sw_index | input | 16 | Software index for perfect mode |
| done | output | 1 | One-cycle result strobe |
| hash_word | output | 32 | Table hash word |

## Verification
Every result is due exactly one clock after the edge that samples `start`. The bench raises `start` at a falling edge and samples `done` and `hash_word` at the next falling edge, half a cycle after the capturing edge. For the hold test, `done` and `hash_word` are sampled again at further falling edges after `start` has dropped. Back-to-back starts are checked at two consecutive falling edges, and then for `done` returning low one cycle later.

// File: rtl/flow_hash_pkg.sv
// Package: shared widths and size-code names for the flow hash engine.
// Assumes 32-bit tuple words and a 16-bit fold value.
package flow_hash_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        SIZE_NONE = 2'd0,
        SIZE_S    = 2'd1,
        SIZE_M    = 2'd2,
        SIZE_L    = 2'd3
    } size_code_e;
endpackage

// File: rtl/tuple_xor.sv
// tuple_xor: splits the flat tuple into the flow word (word 0) and the
// XOR of all remaining words. Purely combinational. Assumes N_WORDS >= 2.
module tuple_xor #(
    parameter int N_WORDS = 14,
    parameter int WORD_W  = 32
) (
    input  logic [N_WORDS*WORD_W-1:0] words_i,
    output logic [WORD_W-1:0]         flow_o,
    output logic [WORD_W-1:0]         common_o
);
    logic [WORD_W-1:0] chain [1:N_WORDS-1];

    assign flow_o = words_i[WORD_W-1:0];
    assign chain[1] = words_i[2*WORD_W-1:WORD_W];

    // XOR chain over words 1..N_WORDS-1
    for (genvar k = 2; k < N_WORDS; k++) begin : g_chain
        assign chain[k] = chain[k-1] ^ words_i[k*WORD_W +: WORD_W];
    end

    assign common_o = chain[N_WORDS-1];
endmodule

// File: rtl/hash_fold.sv
// hash_fold: key-driven shifted-XOR fold of the common and flow words.
// Only the low half of the fold is produced, since that is all the table
// consumes. Key bits 0 and HALF_W act on the working words before the flow
// word is mixed into the low working word. Combinational.
module hash_fold #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]   common_i,
    input  logic [WORD_W-1:0]   flow_i,
    input  logic [WORD_W-1:0]   key_i,
    output logic [WORD_W/2-1:0] fold_o
);
    localparam int H = WORD_W / 2;

    logic [WORD_W-2:0] hi_w;    // high working word, top bit never reaches the fold
    logic [WORD_W-2:1] lo_mix;  // low working word after the flow mix
    logic [H-1:0]      terms [H];

    // High working word: common ^ flow ^ (flow >> H), bit by bit
    for (genvar b = 0; b < WORD_W-1; b++) begin : g_hi
        if (b < H) begin : g_lo_half
            assign hi_w[b] = common_i[b] ^ flow_i[b] ^ flow_i[b+H];
        end else begin : g_up_half
            assign hi_w[b] = common_i[b] ^ flow_i[b];
        end
    end

    // Low working word after mixing: swapped common ^ flow ^ (flow << H)
    for (genvar b = 1; b < WORD_W-1; b++) begin : g_lo
        if (b < H) begin : g_lo_half
            assign lo_mix[b] = common_i[b+H] ^ flow_i[b];
        end else begin : g_up_half
            assign lo_mix[b] = common_i[b-H] ^ flow_i[b] ^ flow_i[b-H];
        end
    end

    // First step uses the unmixed low word (its low half is common[W-1:H])
    assign terms[0] = (key_i[0] ? common_i[WORD_W-1:H] : '0)
                    ^ (key_i[H] ? hi_w[H-1:0]          : '0);

    // Remaining steps: shifted working words selected by key bits i and H+i
    for (genvar i = 1; i < H; i++) begin : g_term
        assign terms[i] = (key_i[i]   ? lo_mix[i +: H] : '0)
                        ^ (key_i[H+i] ? hi_w[i +: H]   : '0);
    end

    // XOR-reduce all step terms into the fold value
    always_comb begin
        fold_o = '0;
        for (int i = 0; i < H; i++) fold_o = fold_o ^ terms[i];
    end
endmodule

// File: rtl/bucket_mask.sv
// bucket_mask: keeps the low bits of the bucket fold. The kept width is the
// mode base width plus the size step; size codes 0 and 1 share the smallest
// width. Assumes SIG_BASE_W + 2 <= HALF_W. Combinational.
module bucket_mask #(
    parameter int HALF_W     = 16,
    parameter int PERF_BASE_W = 11,
    parameter int SIG_BASE_W  = 13
) (
    input  logic              sig_mode_i,
    input  logic [1:0]        size_i,
    input  logic [HALF_W-1:0] fold_i,
    output logic [HALF_W-1:0] bucket_o
);
    localparam int CW = $clog2(HALF_W + 1);

    logic [CW-1:0] keep_w;
    logic [CW-1:0] step_w;

    // Size step: 0 for codes 0 and 1, else code minus one
    always_comb step_w = (size_i == 2'd0) ? '0 : CW'(size_i - 2'd1);

    // Kept width from mode base plus size step
    always_comb keep_w = (sig_mode_i ? CW'(SIG_BASE_W) : CW'(PERF_BASE_W)) + step_w;

    for (genvar b = 0; b < HALF_W; b++) begin : g_bit
        assign bucket_o[b] = fold_i[b] & (keep_w > CW'(b));
    end
endmodule

// File: rtl/flow_hash_engine.sv
// flow_hash_engine: captures a flow tuple on start and produces the table
// hash word one clock later with a one-cycle done strobe. The result is held
// until the next start. Synchronous active-low reset.
module flow_hash_engine #(
    parameter int N_WORDS     = 14,
    parameter int WORD_W      = 32,
    parameter int PERF_BASE_W = 11,
    parameter int SIG_BASE_W  = 13
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [N_WORDS*WORD_W-1:0] flow_words,
    input  logic [WORD_W-1:0]         bucket_key,
    input  logic [WORD_W-1:0]         sig_key,
    input  logic [1:0]                size_code,
    input  logic                      sig_mode,
    input  logic [WORD_W/2-1:0]       sw_index,
    output logic                      done,
    output logic [WORD_W-1:0]         hash_word
);
    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] flow_w, common_w;
    logic [HALF_W-1:0] bkt_fold, sig_fold, bucket_idx, upper_w;
    logic              mode_q;

    tuple_xor #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_xor (
        .words_i(flow_words), .flow_o(flow_w), .common_o(common_w)
    );

    hash_fold #(.WORD_W(WORD_W)) u_bkt_fold (
        .common_i(common_w), .flow_i(flow_w), .key_i(bucket_key), .fold_o(bkt_fold)
    );

    hash_fold #(.WORD_W(WORD_W)) u_sig_fold (
        .common_i(common_w), .flow_i(flow_w), .key_i(sig_key), .fold_o(sig_fold)
    );

    bucket_mask #(.HALF_W(HALF_W), .PERF_BASE_W(PERF_BASE_W), .SIG_BASE_W(SIG_BASE_W)) u_mask (
        .sig_mode_i(sig_mode), .size_i(size_code), .fold_i(bkt_fold), .bucket_o(bucket_idx)
    );

    // Upper field: signature in signature mode, software index otherwise
    always_comb upper_w = sig_mode ? sig_fold : sw_index;

    // Result register: load on start, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_word <= '0;
            mode_q    <= 1'b0;
        end else if (start) begin
            hash_word <= {upper_w, bucket_idx};
            mode_q    <= sig_mode;
        end
    end

    // Done strobe: one cycle per accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= start;
    end

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!done && hash_word == '0));

    // R2: done follows start by one cycle
    p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R2: no done without a start
    p_no_stray_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R3: result held while idle
    p_hold_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(hash_word));

    // R6: perfect-mode bucket never exceeds the widest perfect mask
    p_perf_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_q) |-> (hash_word[HALF_W-1:PERF_BASE_W+2] == '0));

    // R7: signature-mode bucket never exceeds the widest signature mask
    p_sig_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q) |-> (hash_word[HALF_W-1:SIG_BASE_W+2] == '0));
endmodule

// File: tb/sim_flow_hash_engine.sv
module sim_flow_hash_engine;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [447:0] flow_words;
    logic [31:0]  bucket_key, sig_key;
    logic [1:0]   size_code;
    logic         sig_mode;
    logic [15:0]  sw_index;
    logic         done;
    logic [31:0]  hash_word;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    logic [31:0] seed = 32'h1F2E3D4C;

    always #5 clk = ~clk;

    flow_hash_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .flow_words(flow_words),
        .bucket_key(bucket_key), .sig_key(sig_key), .size_code(size_code),
        .sig_mode(sig_mode), .sw_index(sw_index), .done(done), .hash_word(hash_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Reference fold written from the requirement text
    function automatic logic [15:0] ref_fold(input logic [447:0] fw, input logic [31:0] key);
        logic [31:0] cw, fl, lo, hi, res;
        cw = '0;
        for (int k = 1; k < 14; k++) cw = cw ^ fw[k*32 +: 32];
        fl  = fw[31:0];
        lo  = {cw[15:0], cw[31:16]};
        hi  = cw ^ fl ^ (fl >> 16);
        res = '0;
        if (key[0])  res = res ^ lo;
        if (key[16]) res = res ^ hi;
        lo = lo ^ fl ^ (fl << 16);
        for (int i = 15; i >= 1; i--) begin
            if (key[i])    res = res ^ (lo >> i);
            if (key[16+i]) res = res ^ (hi >> i);
        end
        return res[15:0];
    endfunction

    function automatic logic [31:0] ref_word(input logic [447:0] fw, input logic [31:0] bk,
                                             input logic [31:0] sk, input logic [1:0] sz,
                                             input logic sm, input logic [15:0] sw);
        int w;
        logic [15:0] b;
        w = (sm ? 13 : 11) + ((sz == 2'd0) ? 0 : int'(sz) - 1);
        b = ref_fold(fw, bk) & 16'((32'd1 << w) - 1);
        return {sm ? ref_fold(fw, sk) : sw, b};
    endfunction

    // One start pulse, then check done and the word half a cycle after capture
    task automatic run_op(input string tag, input logic [31:0] exp);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " done"}, {31'd0, done}, 32'd1);
        chk({tag, " word"}, hash_word, exp);
    endtask

    task automatic rand_tuple();
        for (int k = 0; k < 14; k++) flow_words[k*32 +: 32] = nxt();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; flow_words = '0; bucket_key = '0; sig_key = '0;
        size_code = '0; sig_mode = 1'b0; sw_index = '0;
        repeat (3) @(negedge clk);
        chk("R1 done after reset", {31'd0, done}, 32'd0);
        chk("R1 word after reset", hash_word, 32'd0);
        rst_n = 1'b1;
    endtask

    // Key bit 0 alone sees the swapped common word before the flow mix
    task automatic t_key_bit0();
        flow_words = '0;
        flow_words[31:0]  = 32'hFFFF_FFFF;
        flow_words[63:32] = 32'h1234_5678;
        bucket_key = 32'h0000_0001; sig_key = 32'hFFFF_FFFF;
        size_code = 2'd3; sig_mode = 1'b0; sw_index = 16'hABCD;
        run_op("R5 key bit0 first-step / R9 sw index", 32'hABCD_1234);
    endtask

    // Same XOR of words 1..13 split differently gives the same word
    task automatic t_common_split();
        logic [31:0] first;
        rand_tuple();
        bucket_key = nxt(); sig_key = nxt(); size_code = 2'd2; sig_mode = 1'b1; sw_index = 16'h0;
        run_op("R4 split A", ref_word(flow_words, bucket_key, sig_key, size_code, sig_mode, sw_index));
        first = hash_word;
        flow_words[2*32 +: 32] = flow_words[2*32 +: 32] ^ 32'h5A5A_0F0F;
        flow_words[9*32 +: 32] = flow_words[9*32 +: 32] ^ 32'h5A5A_0F0F;
        run_op("R4 split B", first);
    endtask

    task automatic t_perfect_sizes();
        for (int s = 0; s < 4; s++) begin
            rand_tuple();
            bucket_key = nxt(); sig_key = nxt(); size_code = 2'(s); sig_mode = 1'b0;
            sw_index = 16'(nxt());
            run_op($sformatf("R6 R9 perfect size %0d", s),
                   ref_word(flow_words, bucket_key, sig_key, size_code, sig_mode, sw_index));
        end
    endtask

    task automatic t_sig_sizes();
        for (int s = 0; s < 4; s++) begin
            rand_tuple();
            bucket_key = nxt(); sig_key = nxt(); size_code = 2'(s); sig_mode = 1'b1;
            sw_index = 16'hFFFF;
            run_op($sformatf("R7 R8 signature size %0d", s),
                   ref_word(flow_words, bucket_key, sig_key, size_code, sig_mode, sw_index));
        end
    endtask

    // Perfect mode: changing only the signature key leaves the word unchanged
    task automatic t_sig_key_ignored();
        logic [31:0] e;
        rand_tuple();
        bucket_key = nxt(); sig_key = 32'h0; size_code = 2'd1; sig_mode = 1'b0; sw_index = 16'h0777;
        e = ref_word(flow_words, bucket_key, sig_key, size_code, sig_mode, sw_index);
        run_op("R9 sig key zero", e);
        sig_key = 32'hDEAD_BEEF;
        run_op("R9 sig key changed", e);
    endtask

    task automatic t_fold_patterns();
        for (int n = 0; n < 6; n++) begin
            rand_tuple();
            bucket_key = nxt(); sig_key = nxt(); size_code = 2'd3; sig_mode = 1'b1;
            run_op($sformatf("R5 fold pattern %0d", n),
                   ref_word(flow_words, bucket_key, sig_key, size_code, sig_mode, sw_index));
        end
    endtask

    task automatic t_hold();
        logic [31:0] e;
        rand_tuple();
        bucket_key = nxt(); sig_key = nxt(); size_code = 2'd2; sig_mode = 1'b1;
        e = ref_word(flow_words, bucket_key, sig_key, size_code, sig_mode, sw_index);
        run_op("R3 before hold", e);
        rand_tuple(); bucket_key = nxt(); sig_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 word held", hash_word, e);
        chk("R2 done single cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] ea, eb;
        @(negedge clk);
        rand_tuple(); bucket_key = nxt(); sig_key = nxt(); size_code = 2'd1; sig_mode = 1'b1;
        ea = ref_word(flow_words, bucket_key, sig_key, size_code, sig_mode, sw_index);
        start = 1'b1;
        @(negedge clk);
        chk("R10 first done", {31'd0, done}, 32'd1);
        chk("R10 first word", hash_word, ea);
        rand_tuple(); sig_mode = 1'b0; sw_index = 16'h4242; size_code = 2'd0;
        eb = ref_word(flow_words, bucket_key, sig_key, size_code, sig_mode, sw_index);
        @(negedge clk);
        start = 1'b0;
        chk("R10 second done", {31'd0, done}, 32'd1);
        chk("R10 second word", hash_word, eb);
        @(negedge clk);
        chk("R2 done drops after burst", {31'd0, done}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_key_bit0();
        t_common_split();
        t_perfect_sizes();
        t_sig_sizes();
        t_sig_key_ignored();
        t_fold_patterns();
        t_hold();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule